// File: doc/BRIEF.md
# Counter Delegation Indirect CSR Window

This block gives supervisor software a path to the machine-level performance counters and their event selectors. Software does not use their direct machine addresses. It writes a select value that names one counter slot, then accesses one of six alias registers. Each alias presents a different 32-bit view of that slot: the counter low or high half, or the event selector low or high half. Two aliases have no backing storage.

Each request is checked against the current privilege and the virtualization bit. It is also checked against the delegation enable that the machine environment configuration supplies, and against the machine counter-enable mask. The block then returns one of three results: allowed, illegal instruction or virtual instruction. The counter and event register files are held inside the block as plain registers. Incrementing them is left to other logic, which receives the per-slot machine-inhibit bits.

A request is presented for one cycle with `req_valid` high. The read data and the trap code are combinational in that same cycle. An allowed write is committed at the next rising clock edge. The window accepts a request in every cycle, so there is no back-pressure and no ready signal. When `req_valid` is low, the inputs are ignored.

Top module: `cdeleg_window`

## Requirements
- R1: The slot offset is `req_sel - WIN_BASE` (default base 0x40). The window spans 32 offsets. Offset 0 is the cycle counter, offset 1 has no registers, offset 2 is the retired-instruction counter, and offsets 3 to 2+NUM_PROG are programmable counters. Any higher offset has no registers.
- R2: Aliases are numbered on `req_alias`. Alias 1 is counter bits 31:0, alias 4 is counter bits 63:32, alias 2 is event bits 31:0 and alias 5 is event bits 63:32. An allowed access returns the current value on `resp_rdata`. An allowed write stores `req_wdata` at the next rising edge.
- R3: From HS or M mode, an access to alias 3 or alias 6, or to a slot without registers, gives trap code 1 (illegal).
- R4: The machine-inhibit bit is bit 62 of the 64-bit event register, which is bit 30 of alias 5. It reads as 0 through the window. A write keeps its old value while every other bit takes the written value. `minh_out[s]` carries the stored bit of slot s.
- R5: From HS mode (`req_priv`=1, `req_virt`=0) or M mode (`req_priv`=3, `req_virt`=0), an access traps with code 1 when `cfg_deleg_en` is 0 or when `cnt_en[offset]` is 0.
- R6: From VS mode (`req_priv`=1, `req_virt`=1), any access with a valid alias number gives code 2 (virtual) when `cfg_deleg_en` is 1 and code 1 when it is 0.
- R7: An access to the virtual-supervisor copy of the window (`req_vcopy`=1) from HS or M mode gives code 1.
- R8: The following accesses give code 1 and touch no register: a select outside the window from HS or M mode, U mode (`req_priv`=0), the reserved privilege 2, and alias numbers 0 and 7.
- R9: A trapped access returns `resp_rdata`=0 and changes no register. A cycle with `req_valid` low returns code 0 and data 0 and changes nothing, whatever the other inputs are.
- R10: After reset every counter is 0 and every event register holds EVT_INIT, which has the machine-inhibit bit set by default. Slots without registers drive 0 on `minh_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_alias | input | 3 | Alias number 1 to 6 |
| req_vcopy | input | 1 | Access targets the virtual-supervisor copy of the window |
| req_sel | input | SELW | Select value naming the slot |
| req_we | input | 1 | 1 for a write |
| req_wdata | input | DW | Write data |
| req_priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| req_virt | input | 1 | Virtualization bit |
| cfg_deleg_en | input | 1 | Delegation enable (bit 60 of the machine environment config, bit 28 of its high word) |
| cnt_en | input | 32 | Machine counter-enable mask, indexed by slot offset |
| resp_rdata | output | DW | Read data, 0 on a trap |
| resp_trap | output | 2 | 0 none, 1 illegal, 2 virtual |
| minh_out | output | 32 | Stored machine-inhibit bit of each slot |

## Verification
On every request cycle the assertions check the trap decision against its inputs: the VS-mode outcome, the gating by the delegation enable and by the counter-enable bit, and the out-of-window select. They also check that a trap returns zero data, that an alias 5 read never shows the inhibit bit, and that neither a trapped write nor an alias 5 write disturbs the stored inhibit bits. Only the bench scenarios can show that data written through one alias comes back through the right view of the right slot. The same holds for the cases that the properties do not cover: slots and aliases without registers, the virtual-copy flag and the reset contents.

// File: rtl/cdw_pkg.sv
package cdw_pkg;
  localparam int SLOTS = 32;
  localparam int OFFW  = $clog2(SLOTS);

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_ILL  = 2'd1,
    TRAP_VIRT = 2'd2
  } trap_e;

  typedef enum logic [1:0] {
    FLD_CTR_LO = 2'd0,
    FLD_EVT_LO = 2'd1,
    FLD_CTR_HI = 2'd2,
    FLD_EVT_HI = 2'd3
  } field_e;

  // A slot carries storage when it is the cycle counter, the retired counter
  // or one of the implemented programmable counters.
  function automatic logic slot_has_reg(input int s, input int nprog);
    return (s == 0) || (s == 2) || ((s >= 3) && (s < 3 + nprog));
  endfunction
endpackage

// File: rtl/cdw_decode.sv
module cdw_decode
  import cdw_pkg::*;
#(
  parameter int SELW     = 12,
  parameter int WIN_BASE = 'h40,
  parameter int NUM_PROG = 29
) (
  input  logic [SELW-1:0] sel,
  input  logic [2:0]      alias_num,
  output logic            in_win,
  output logic [OFFW-1:0] off,
  output logic            slot_backed,
  output logic            alias_valid,
  output logic            alias_backed,
  output field_e          fld
);
  logic [SELW-1:0]  diff;
  logic [SLOTS-1:0] backed_map;

  assign diff   = sel - SELW'(WIN_BASE);
  assign in_win = (sel >= SELW'(WIN_BASE)) && (diff < SELW'(SLOTS));
  assign off    = diff[OFFW-1:0];

  for (genvar g = 0; g < SLOTS; g++) begin : g_map
    assign backed_map[g] = slot_has_reg(g, NUM_PROG);
  end

  assign slot_backed = backed_map[off];

  always_comb begin
    alias_valid  = 1'b1;
    alias_backed = 1'b1;
    fld          = FLD_CTR_LO;
    unique case (alias_num)
      3'd1: fld = FLD_CTR_LO;
      3'd2: fld = FLD_EVT_LO;
      3'd4: fld = FLD_CTR_HI;
      3'd5: fld = FLD_EVT_HI;
      3'd3, 3'd6: alias_backed = 1'b0;
      default: begin
        alias_valid  = 1'b0;
        alias_backed = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cdw_guard.sv
module cdw_guard
  import cdw_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       vcopy,
  input  logic       in_win,
  input  logic       slot_backed,
  input  logic       alias_valid,
  input  logic       alias_backed,
  input  logic       deleg_en,
  input  logic       cnt_bit,
  output trap_e      trap
);
  logic vs_mode;
  logic hs_or_m;

  assign vs_mode = (priv == PRIV_S) && virt;
  assign hs_or_m = ((priv == PRIV_S) || (priv == PRIV_M)) && !virt;

  always_comb begin
    trap = TRAP_NONE;
    if (!alias_valid) begin
      trap = TRAP_ILL;
    end else if (vs_mode) begin
      // A guest never reaches the window: deflect to the hypervisor when
      // delegation is on, otherwise report it as a plain illegal access.
      trap = deleg_en ? TRAP_VIRT : TRAP_ILL;
    end else if (!hs_or_m) begin
      trap = TRAP_ILL;
    end else if (vcopy || !in_win || !slot_backed || !alias_backed ||
                 !deleg_en || !cnt_bit) begin
      trap = TRAP_ILL;
    end
  end
endmodule

// File: rtl/cdw_bank.sv
module cdw_bank
  import cdw_pkg::*;
#(
  parameter int              NUM_PROG = 29,
  parameter int              DW       = 32,
  parameter logic [2*DW-1:0] EVT_INIT = 64'h4000_0000_0000_0000,
  parameter int              MINH_BIT = 62
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [OFFW-1:0] wr_slot,
  input  field_e          wr_fld,
  input  logic [DW-1:0]   wr_data,
  input  logic [OFFW-1:0] rd_slot,
  input  field_e          rd_fld,
  output logic [DW-1:0]   rd_data,
  output logic [SLOTS-1:0] minh
);
  localparam int CW = 2 * DW;
  localparam logic [CW-1:0] MINH_M  = {{(CW-1){1'b0}}, 1'b1} << MINH_BIT;
  localparam logic [DW-1:0] KEEP_LO = MINH_M[DW-1:0];
  localparam logic [DW-1:0] KEEP_HI = MINH_M[CW-1:DW];

  logic [SLOTS-1:0][CW-1:0] ctr_w;
  logic [SLOTS-1:0][CW-1:0] evt_w;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (slot_has_reg(g, NUM_PROG)) begin : g_reg
      logic [CW-1:0] ctr_r;
      logic [CW-1:0] evt_r;
      logic          hit;
      assign hit = wr_en && (wr_slot == OFFW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctr_r <= '0;
          evt_r <= EVT_INIT;
        end else if (hit) begin
          unique case (wr_fld)
            FLD_CTR_LO: ctr_r[DW-1:0]  <= wr_data;
            FLD_CTR_HI: ctr_r[CW-1:DW] <= wr_data;
            FLD_EVT_LO: evt_r[DW-1:0]  <= (wr_data & ~KEEP_LO) | (evt_r[DW-1:0] & KEEP_LO);
            FLD_EVT_HI: evt_r[CW-1:DW] <= (wr_data & ~KEEP_HI) | (evt_r[CW-1:DW] & KEEP_HI);
            default: ;
          endcase
        end
      end
      assign ctr_w[g] = ctr_r;
      assign evt_w[g] = evt_r;
      assign minh[g]  = evt_r[MINH_BIT];
    end else begin : g_none
      assign ctr_w[g] = '0;
      assign evt_w[g] = '0;
      assign minh[g]  = 1'b0;
    end
  end

  always_comb begin
    unique case (rd_fld)
      FLD_CTR_LO: rd_data = ctr_w[rd_slot][DW-1:0];
      FLD_CTR_HI: rd_data = ctr_w[rd_slot][CW-1:DW];
      FLD_EVT_LO: rd_data = evt_w[rd_slot][DW-1:0] & ~KEEP_LO;
      FLD_EVT_HI: rd_data = evt_w[rd_slot][CW-1:DW] & ~KEEP_HI;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cdeleg_window.sv
module cdeleg_window
  import cdw_pkg::*;
#(
  parameter int              SELW     = 12,
  parameter int              WIN_BASE = 'h40,
  parameter int              NUM_PROG = 29,
  parameter int              DW       = 32,
  parameter logic [2*DW-1:0] EVT_INIT = 64'h4000_0000_0000_0000,
  parameter int              MINH_BIT = 62
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_alias,
  input  logic             req_vcopy,
  input  logic [SELW-1:0]  req_sel,
  input  logic             req_we,
  input  logic [DW-1:0]    req_wdata,
  input  logic [1:0]       req_priv,
  input  logic             req_virt,
  input  logic             cfg_deleg_en,
  input  logic [SLOTS-1:0] cnt_en,
  output logic [DW-1:0]    resp_rdata,
  output logic [1:0]       resp_trap,
  output logic [SLOTS-1:0] minh_out
);
  logic            in_win;
  logic [OFFW-1:0] off;
  logic            slot_backed;
  logic            alias_valid;
  logic            alias_backed;
  field_e          fld;
  trap_e           trap;
  logic            grant;
  logic [DW-1:0]   bank_rd;

  cdw_decode #(
    .SELW(SELW), .WIN_BASE(WIN_BASE), .NUM_PROG(NUM_PROG)
  ) u_decode (
    .sel          (req_sel),
    .alias_num    (req_alias),
    .in_win       (in_win),
    .off          (off),
    .slot_backed  (slot_backed),
    .alias_valid  (alias_valid),
    .alias_backed (alias_backed),
    .fld          (fld)
  );

  cdw_guard u_guard (
    .priv         (req_priv),
    .virt         (req_virt),
    .vcopy        (req_vcopy),
    .in_win       (in_win),
    .slot_backed  (slot_backed),
    .alias_valid  (alias_valid),
    .alias_backed (alias_backed),
    .deleg_en     (cfg_deleg_en),
    .cnt_bit      (cnt_en[off]),
    .trap         (trap)
  );

  assign grant = req_valid && (trap == TRAP_NONE);

  cdw_bank #(
    .NUM_PROG(NUM_PROG), .DW(DW), .EVT_INIT(EVT_INIT), .MINH_BIT(MINH_BIT)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (grant && req_we),
    .wr_slot (off),
    .wr_fld  (fld),
    .wr_data (req_wdata),
    .rd_slot (off),
    .rd_fld  (fld),
    .rd_data (bank_rd),
    .minh    (minh_out)
  );

  assign resp_rdata = grant ? bank_rd : '0;
  assign resp_trap  = req_valid ? trap : TRAP_NONE;
endmodule

// File: rtl/cdw_checker.sv
module cdw_checker #(
  parameter int SELW     = 12,
  parameter int WIN_BASE = 'h40,
  parameter int DW       = 32,
  parameter int MINH_BIT = 62
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [2:0]      req_alias,
  input logic [SELW-1:0] req_sel,
  input logic            req_we,
  input logic [1:0]      req_priv,
  input logic            req_virt,
  input logic            cfg_deleg_en,
  input logic [31:0]     cnt_en,
  input logic [DW-1:0]   resp_rdata,
  input logic [1:0]      resp_trap,
  input logic [31:0]     minh_out
);
  localparam logic [2*DW-1:0] MM  = {{(2*DW-1){1'b0}}, 1'b1} << MINH_BIT;
  localparam logic [DW-1:0]   MHI = MM[2*DW-1:DW];

  logic [SELW-1:0] d;
  logic            in_w;
  logic            vs;
  logic            hsm;
  logic            ok_alias;

  assign d        = req_sel - SELW'(WIN_BASE);
  assign in_w     = (req_sel >= SELW'(WIN_BASE)) && (d < SELW'(32));
  assign vs       = (req_priv == 2'd1) && req_virt;
  assign hsm      = ((req_priv == 2'd1) || (req_priv == 2'd3)) && !req_virt;
  assign ok_alias = (req_alias != 3'd0) && (req_alias != 3'd7);

  assert_vs_virtual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vs && ok_alias && cfg_deleg_en |-> resp_trap == 2'd2);

  assert_vs_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vs && !cfg_deleg_en |-> resp_trap == 2'd1);

  assert_deleg_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hsm && !cfg_deleg_en |-> resp_trap == 2'd1);

  assert_cnt_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hsm && in_w && !cnt_en[d[4:0]] |-> resp_trap == 2'd1);

  assert_out_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hsm && !in_w |-> resp_trap == 2'd1);

  assert_zero_on_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_trap != 2'd0 |-> resp_rdata == '0);

  assert_hold_on_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_we && resp_trap != 2'd0 |=> $stable(minh_out));

  assert_minh_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && resp_trap == 2'd0 && req_alias == 3'd5 |-> (resp_rdata & MHI) == '0);

  assert_minh_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_we && (req_alias == 3'd5 || req_alias == 3'd2) |=> $stable(minh_out));
endmodule

bind cdeleg_window cdw_checker #(
  .SELW(SELW), .WIN_BASE(WIN_BASE), .DW(DW), .MINH_BIT(MINH_BIT)
) u_cdw_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_alias    (req_alias),
  .req_sel      (req_sel),
  .req_we       (req_we),
  .req_priv     (req_priv),
  .req_virt     (req_virt),
  .cfg_deleg_en (cfg_deleg_en),
  .cnt_en       (cnt_en),
  .resp_rdata   (resp_rdata),
  .resp_trap    (resp_trap),
  .minh_out     (minh_out)
);

// File: tb/test_cdeleg_window.sv
`timescale 1ns/1ps
module test_cdeleg_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_alias = 3'd1;
  logic        req_vcopy = 1'b0;
  logic [11:0] req_sel = 12'h040;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_priv = 2'd1;
  logic        req_virt = 1'b0;
  logic        cfg_deleg_en = 1'b1;
  logic [31:0] cnt_en = 32'hFFFF_FFFF;
  logic [31:0] resp_rdata;
  logic [1:0]  resp_trap;
  logic [31:0] minh_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] got_rd;
  logic [1:0]  got_tr;

  always #4 clk = ~clk;

  cdeleg_window #(.NUM_PROG(13)) i_cdeleg_window (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_alias(req_alias),
    .req_vcopy(req_vcopy), .req_sel(req_sel), .req_we(req_we),
    .req_wdata(req_wdata), .req_priv(req_priv), .req_virt(req_virt),
    .cfg_deleg_en(cfg_deleg_en), .cnt_en(cnt_en), .resp_rdata(resp_rdata),
    .resp_trap(resp_trap), .minh_out(minh_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive one request after a falling edge, sample it 2 ns later,
  // and let the following rising edge commit it.
  task automatic acc(input logic [2:0] a, input logic vc, input logic [11:0] s,
                     input logic w, input logic [31:0] dat, input logic [1:0] p,
                     input logic v, input logic valid = 1'b1);
    @(negedge clk);
    req_valid = valid; req_alias = a; req_vcopy = vc; req_sel = s;
    req_we = w; req_wdata = dat; req_priv = p; req_virt = v;
    #2;
    got_rd = resp_rdata;
    got_tr = resp_trap;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 minh after reset", minh_out, 32'h0000_FFFD);
    chk("R10 idle trap", {30'd0, resp_trap}, 32'd0);
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R10 cycle counter reset", got_rd, 32'd0);
    acc(3'd2, 1'b0, 12'h04F, 1'b0, 0, 2'd1, 1'b0);
    chk("R10 event low reset", got_rd, 32'd0);
  endtask

  task automatic t_counter;
    acc(3'd1, 1'b0, 12'h040, 1'b1, 32'h1234_5678, 2'd1, 1'b0);
    chk("R2 write trap", {30'd0, got_tr}, 32'd0);
    acc(3'd4, 1'b0, 12'h040, 1'b1, 32'hA5A5_0001, 2'd1, 1'b0);
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R2 cycle low", got_rd, 32'h1234_5678);
    acc(3'd4, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R2 cycle high", got_rd, 32'hA5A5_0001);
    acc(3'd1, 1'b0, 12'h042, 1'b1, 32'hDEAD_0002, 2'd1, 1'b0);
    acc(3'd1, 1'b0, 12'h042, 1'b0, 0, 2'd1, 1'b0);
    chk("R1 retired counter slot", got_rd, 32'hDEAD_0002);
    acc(3'd1, 1'b0, 12'h04F, 1'b1, 32'h0000_00FF, 2'd3, 1'b0);
    acc(3'd1, 1'b0, 12'h04F, 1'b0, 0, 2'd3, 1'b0);
    chk("R1 last programmable slot from M", got_rd, 32'h0000_00FF);
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R2 slot 0 untouched", got_rd, 32'h1234_5678);
  endtask

  task automatic t_event;
    acc(3'd5, 1'b0, 12'h043, 1'b0, 0, 2'd1, 1'b0);
    chk("R4 inhibit hidden on read", got_rd, 32'd0);
    acc(3'd5, 1'b0, 12'h043, 1'b1, 32'hFFFF_FFFF, 2'd1, 1'b0);
    acc(3'd5, 1'b0, 12'h043, 1'b0, 0, 2'd1, 1'b0);
    chk("R4 other bits written", got_rd, 32'hBFFF_FFFF);
    chk("R4 inhibit kept", minh_out, 32'h0000_FFFD);
    acc(3'd2, 1'b0, 12'h043, 1'b1, 32'h1357_9BDF, 2'd1, 1'b0);
    acc(3'd2, 1'b0, 12'h043, 1'b0, 0, 2'd1, 1'b0);
    chk("R2 event low", got_rd, 32'h1357_9BDF);
  endtask

  task automatic t_missing;
    acc(3'd3, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R3 alias 3", {30'd0, got_tr}, 32'd1);
    acc(3'd6, 1'b0, 12'h042, 1'b0, 0, 2'd3, 1'b0);
    chk("R3 alias 6", {30'd0, got_tr}, 32'd1);
    acc(3'd1, 1'b0, 12'h041, 1'b0, 0, 2'd1, 1'b0);
    chk("R3 unused slot 1", {30'd0, got_tr}, 32'd1);
    acc(3'd1, 1'b0, 12'h050, 1'b0, 0, 2'd1, 1'b0);
    chk("R3 slot past programmable", {30'd0, got_tr}, 32'd1);
    chk("R3 data zero", got_rd, 32'd0);
  endtask

  task automatic t_gates;
    cfg_deleg_en = 1'b0;
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R5 delegation off", {30'd0, got_tr}, 32'd1);
    cfg_deleg_en = 1'b1;
    cnt_en = ~32'h0000_0004;
    acc(3'd1, 1'b0, 12'h042, 1'b0, 0, 2'd3, 1'b0);
    chk("R5 counter enable clear", {30'd0, got_tr}, 32'd1);
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R5 other slot still open", got_rd, 32'h1234_5678);
    cnt_en = 32'hFFFF_FFFF;
  endtask

  task automatic t_vs;
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b1);
    chk("R6 VS virtual", {30'd0, got_tr}, 32'd2);
    acc(3'd3, 1'b0, 12'h010, 1'b0, 0, 2'd1, 1'b1);
    chk("R6 VS any alias any select", {30'd0, got_tr}, 32'd2);
    cfg_deleg_en = 1'b0;
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b1);
    chk("R6 VS illegal without delegation", {30'd0, got_tr}, 32'd1);
    cfg_deleg_en = 1'b1;
  endtask

  task automatic t_vcopy;
    acc(3'd1, 1'b1, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R7 virtual copy from HS", {30'd0, got_tr}, 32'd1);
    acc(3'd2, 1'b1, 12'h043, 1'b0, 0, 2'd3, 1'b0);
    chk("R7 virtual copy from M", {30'd0, got_tr}, 32'd1);
  endtask

  task automatic t_bad;
    acc(3'd1, 1'b0, 12'h03F, 1'b0, 0, 2'd1, 1'b0);
    chk("R8 below window", {30'd0, got_tr}, 32'd1);
    acc(3'd1, 1'b0, 12'h060, 1'b0, 0, 2'd1, 1'b0);
    chk("R8 above window", {30'd0, got_tr}, 32'd1);
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd0, 1'b0);
    chk("R8 U mode", {30'd0, got_tr}, 32'd1);
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd2, 1'b0);
    chk("R8 reserved privilege", {30'd0, got_tr}, 32'd1);
    acc(3'd7, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R8 alias 7", {30'd0, got_tr}, 32'd1);
    acc(3'd0, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R8 alias 0", {30'd0, got_tr}, 32'd1);
  endtask

  task automatic t_trapwrite;
    cfg_deleg_en = 1'b0;
    acc(3'd1, 1'b0, 12'h040, 1'b1, 32'hFFFF_FFFF, 2'd1, 1'b0);
    chk("R9 trapped write code", {30'd0, got_tr}, 32'd1);
    chk("R9 trapped write data", got_rd, 32'd0);
    cfg_deleg_en = 1'b1;
    acc(3'd1, 1'b0, 12'h040, 1'b1, 32'hFFFF_FFFF, 2'd1, 1'b1);
    acc(3'd1, 1'b0, 12'h040, 1'b1, 32'h0BAD_0BAD, 2'd1, 1'b0, 1'b0);
    chk("R9 idle code", {30'd0, got_tr}, 32'd0);
    chk("R9 idle data", got_rd, 32'd0);
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R9 counter unchanged", got_rd, 32'h1234_5678);
    acc(3'd1, 1'b0, 12'h060, 1'b1, 32'h0, 2'd1, 1'b0);
    acc(3'd1, 1'b0, 12'h040, 1'b0, 0, 2'd1, 1'b0);
    chk("R8 out-of-window write touches nothing", got_rd, 32'h1234_5678);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_counter();
    t_event();
    t_missing();
    t_gates();
    t_vs();
    t_vcopy();
    t_bad();
    t_trapwrite();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule